// File: doc/BRIEF.md
# Double-Buffered Endpoint Buffer Command Controller

This block keeps the bookkeeping for one endpoint. The endpoint has two transmit buffers, used alternately, and a single receive buffer. A microcontroller sends it 8-bit command codes. A validate command marks the buffer being filled as ready to send. A clear command forcibly frees a transmit buffer. A restart command rewinds every pointer to the start of the endpoint storage. The packet engine sends a one-cycle pulse each time a packet has gone out on the bus, and the buffer that held it is then freed automatically.

The data path reports each word it moves with increment pulses: a write or read into the transmit side, and a write or read into the receive side. The block returns four things: the valid state of both transmit buffers, which buffer is being filled and which is next to send, a full flag, and the four pointers. The packet engine, the storage array and the DMA movement sit outside this block. Reset is asynchronous active-low, and its release is synchronised inside the block, which adds two cycles.

Top module: `epbuf_ctrl`

## Requirements
- R1: A command takes effect only when `cmd_valid` is high. Code 0x0E is validate, 0x0F is clear and 0x10 is restart. Any other code changes no output.
- R2: Validate sets the valid flag of the fill buffer (`tx_fill_sel`), toggles `tx_fill_sel` and sets `tx_wr_ptr` to 0. When that buffer is already valid, validate does nothing.
- R3: `tx_wr_inc` advances `tx_wr_ptr` by one, modulo 2^PTR_W (64 by default), only while the fill buffer is not valid. Otherwise the pointer holds.
- R4: Clear frees the oldest valid transmit buffer (`tx_send_sel`), one buffer per command. It toggles `tx_send_sel` and sets `tx_rd_ptr` to 0. Two clears are needed to free both buffers.
- R5: Clear issued while no transmit buffer is valid has no effect.
- R6: Clear never changes `rx_wr_ptr` or `rx_rd_ptr`.
- R7: `pkt_sent` frees the oldest valid buffer exactly as clear does. When clear and `pkt_sent` arrive in the same cycle, two buffers are freed, oldest first, limited to the number of buffers that are valid.
- R8: Restart sets all four pointers to 0 and leaves the valid flags and both selects unchanged. Restart overrides any increment in the same cycle.
- R9: `tx_full` is high exactly when both transmit valid flags (bit 0 for buffer 0, bit 1 for buffer 1) are set.
- R10: `tx_rd_inc` advances `tx_rd_ptr` only while the send buffer is valid.
- R11: While `rst_n` is low, every output is 0. This takes effect at once, without waiting for a clock edge.
- R12: `rx_wr_inc` and `rx_rd_inc` each advance their own receive pointer by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| tx_wr_inc | input | 1 | One word written into the fill buffer |
| tx_rd_inc | input | 1 | One word read from the send buffer |
| rx_wr_inc | input | 1 | One word written into the receive buffer |
| rx_rd_inc | input | 1 | One word read from the receive buffer |
| pkt_sent | input | 1 | Packet from the send buffer has left on the bus |
| tx_full | output | 1 | Both transmit buffers valid |
| tx_valid | output | 2 | Valid flag per transmit buffer |
| tx_fill_sel | output | 1 | Buffer being filled |
| tx_send_sel | output | 1 | Oldest valid buffer, next to send |
| tx_wr_ptr | output | PTR_W | Transmit write pointer |
| tx_rd_ptr | output | PTR_W | Transmit read pointer |
| rx_wr_ptr | output | PTR_W | Receive write pointer |
| rx_rd_ptr | output | PTR_W | Receive read pointer |

## Verification
The ping-pong sequence is driven through every occupancy (none, one and two buffers valid), so that a swapped select or an unconditional update shows up. Validate and write are repeated while the endpoint is full, to tell a guarded update from an unguarded one. Freeing is tried three ways: clear alone, the packet-sent pulse alone, and both in one cycle. This separates single release, release of two buffers and the no-op on an empty endpoint, and it shows that the receive pointers stay where they were. Restart is issued together with a write, and a long run of writes wraps the pointer, which exposes any wrong priority or a width error.

// File: rtl/epbuf_pkg.sv
package epbuf_pkg;
  localparam logic [7:0] CODE_VALIDATE = 8'h0E;
  localparam logic [7:0] CODE_CLEAR    = 8'h0F;
  localparam logic [7:0] CODE_RESTART  = 8'h10;

  typedef enum logic [1:0] {
    OP_NONE     = 2'd0,
    OP_VALIDATE = 2'd1,
    OP_CLEAR    = 2'd2,
    OP_RESTART  = 2'd3
  } ebc_op_e;
endpackage

// File: rtl/ebc_rst_sync.sv
module ebc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ebc_cmd_decode.sv
module ebc_cmd_decode
  import epbuf_pkg::*;
(
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  output ebc_op_e    op
);
  always_comb begin
    op = OP_NONE;
    if (cmd_valid) begin
      unique case (cmd_code)
        CODE_VALIDATE: op = OP_VALIDATE;
        CODE_CLEAR:    op = OP_CLEAR;
        CODE_RESTART:  op = OP_RESTART;
        default:       op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ebc_tx_ring.sv
module ebc_tx_ring
  import epbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ebc_op_e    op,
  input  logic       pkt_sent,
  output logic [1:0] valid,
  output logic       fill_sel,
  output logic       send_sel,
  output logic       validate_ok,
  output logic       release_any
);
  logic [1:0] valid_q, valid_d;
  logic       fill_q, fill_d;
  logic       send_q, send_d;
  logic [1:0] rel_req, nvalid, n_rel;
  logic       state_en;

  always_comb begin
    rel_req = 2'(op == OP_CLEAR) + 2'(pkt_sent);
    case (valid_q)
      2'b00:   nvalid = 2'd0;
      2'b11:   nvalid = 2'd2;
      default: nvalid = 2'd1;
    endcase
    n_rel   = (rel_req < nvalid) ? rel_req : nvalid;
    valid_d = valid_q;
    fill_d  = fill_q;
    send_d  = send_q;
    // release oldest first; two releases free both and leave the order unchanged
    if (n_rel == 2'd2) begin
      valid_d = 2'b00;
    end else if (n_rel == 2'd1) begin
      valid_d[send_q] = 1'b0;
      send_d          = ~send_q;
    end
    validate_ok = (op == OP_VALIDATE) && !valid_q[fill_q];
    if (validate_ok) begin
      valid_d[fill_q] = 1'b1;
      fill_d          = ~fill_q;
    end
    release_any = (n_rel != 2'd0);
    state_en    = release_any | validate_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 2'b00;
      fill_q  <= 1'b0;
      send_q  <= 1'b0;
    end else if (state_en) begin
      valid_q <= valid_d;
      fill_q  <= fill_d;
      send_q  <= send_d;
    end
  end

  assign valid    = valid_q;
  assign fill_sel = fill_q;
  assign send_sel = send_q;
endmodule

// File: rtl/ebc_ptr.sv
module ebc_ptr #(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             rewind,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_en = inc | rewind;
    ptr_d  = rewind ? '0 : ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/epbuf_ctrl.sv
module epbuf_ctrl
  import epbuf_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_code,
  input  logic             tx_wr_inc,
  input  logic             tx_rd_inc,
  input  logic             rx_wr_inc,
  input  logic             rx_rd_inc,
  input  logic             pkt_sent,
  output logic             tx_full,
  output logic [1:0]       tx_valid,
  output logic             tx_fill_sel,
  output logic             tx_send_sel,
  output logic [PTR_W-1:0] tx_wr_ptr,
  output logic [PTR_W-1:0] tx_rd_ptr,
  output logic [PTR_W-1:0] rx_wr_ptr,
  output logic [PTR_W-1:0] rx_rd_ptr
);
  localparam int N_PTR = 4;
  localparam int P_TXW = 0;
  localparam int P_TXR = 1;
  localparam int P_RXW = 2;
  localparam int P_RXR = 3;

  logic             rst_core_n;
  ebc_op_e          op;
  logic             validate_ok, release_any, restart;
  logic [N_PTR-1:0] p_inc, p_rew;
  logic [PTR_W-1:0] p_val [N_PTR];

  ebc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  ebc_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .op        (op)
  );

  ebc_tx_ring u_ring (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .op          (op),
    .pkt_sent    (pkt_sent),
    .valid       (tx_valid),
    .fill_sel    (tx_fill_sel),
    .send_sel    (tx_send_sel),
    .validate_ok (validate_ok),
    .release_any (release_any)
  );

  always_comb begin
    restart      = (op == OP_RESTART);
    p_inc[P_TXW] = tx_wr_inc & ~tx_valid[tx_fill_sel];
    p_inc[P_TXR] = tx_rd_inc &  tx_valid[tx_send_sel];
    p_inc[P_RXW] = rx_wr_inc;
    p_inc[P_RXR] = rx_rd_inc;
    p_rew[P_TXW] = restart | validate_ok;
    p_rew[P_TXR] = restart | release_any;
    p_rew[P_RXW] = restart;
    p_rew[P_RXR] = restart;
  end

  for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
    ebc_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .inc    (p_inc[g]),
      .rewind (p_rew[g]),
      .ptr    (p_val[g])
    );
  end

  assign tx_full   = &tx_valid;
  assign tx_wr_ptr = p_val[P_TXW];
  assign tx_rd_ptr = p_val[P_TXR];
  assign rx_wr_ptr = p_val[P_RXW];
  assign rx_rd_ptr = p_val[P_RXR];
endmodule

// File: rtl/epbuf_ctrl_chk.sv
module epbuf_ctrl_chk
  import epbuf_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [7:0]       cmd_code,
  input logic             tx_wr_inc,
  input logic             rx_wr_inc,
  input logic             rx_rd_inc,
  input logic             pkt_sent,
  input logic             tx_full,
  input logic [1:0]       tx_valid,
  input logic             tx_fill_sel,
  input logic             tx_send_sel,
  input logic [PTR_W-1:0] tx_wr_ptr,
  input logic [PTR_W-1:0] tx_rd_ptr,
  input logic [PTR_W-1:0] rx_wr_ptr,
  input logic [PTR_W-1:0] rx_rd_ptr
);
  logic c_val, c_clr, c_rst, c_other;
  assign c_val   = cmd_valid && cmd_code == CODE_VALIDATE;
  assign c_clr   = cmd_valid && cmd_code == CODE_CLEAR;
  assign c_rst   = cmd_valid && cmd_code == CODE_RESTART;
  assign c_other = cmd_valid && !c_val && !c_clr && !c_rst;

  AST_UNKNOWN_CODE_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    c_other && !pkt_sent |=> $stable(tx_valid) && $stable(tx_fill_sel) && $stable(tx_send_sel)); // R1
  AST_VALIDATE_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
    c_val && !tx_full && !pkt_sent |=> $countones(tx_valid) == $countones($past(tx_valid)) + 1); // R2
  AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full && tx_wr_inc && !c_rst |=> $stable(tx_wr_ptr)); // R3
  AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    c_clr && !pkt_sent && tx_valid != 2'b00 |=> $countones(tx_valid) == $countones($past(tx_valid)) - 1); // R4
  AST_CLEAR_EMPTY_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    c_clr && tx_valid == 2'b00 |=> tx_valid == 2'b00 && $stable(tx_send_sel) && $stable(tx_rd_ptr)); // R5
  AST_CLEAR_KEEPS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    c_clr && !rx_wr_inc && !rx_rd_inc |=> $stable(rx_wr_ptr) && $stable(rx_rd_ptr)); // R6
  AST_SENT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_sent && !cmd_valid && tx_valid != 2'b00 |=> $countones(tx_valid) == $countones($past(tx_valid)) - 1); // R7
  AST_RESTART_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
    c_rst |=> tx_wr_ptr == '0 && tx_rd_ptr == '0 && rx_wr_ptr == '0 && rx_rd_ptr == '0); // R8
  AST_RESTART_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    c_rst && !pkt_sent |=> $stable(tx_valid) && $stable(tx_fill_sel)); // R8
endmodule

bind epbuf_ctrl epbuf_ctrl_chk #(.PTR_W(PTR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_code    (cmd_code),
  .tx_wr_inc   (tx_wr_inc),
  .rx_wr_inc   (rx_wr_inc),
  .rx_rd_inc   (rx_rd_inc),
  .pkt_sent    (pkt_sent),
  .tx_full     (tx_full),
  .tx_valid    (tx_valid),
  .tx_fill_sel (tx_fill_sel),
  .tx_send_sel (tx_send_sel),
  .tx_wr_ptr   (tx_wr_ptr),
  .tx_rd_ptr   (tx_rd_ptr),
  .rx_wr_ptr   (rx_wr_ptr),
  .rx_rd_ptr   (rx_rd_ptr)
);

// File: tb/epbuf_ctrl_test.sv
`timescale 1ns/100ps
module epbuf_ctrl_test;
  localparam int PTR_W = 6;
  localparam int IN_W  = 14;
  localparam int EX_W  = 5 + 4 * PTR_W;
  localparam int ROW_W = IN_W + EX_W + 4;
  localparam int N_ROW = 19;

  logic             clk, rst_n;
  logic             cmd_valid, tx_wr_inc, tx_rd_inc, rx_wr_inc, rx_rd_inc, pkt_sent;
  logic [7:0]       cmd_code;
  logic             tx_full, tx_fill_sel, tx_send_sel;
  logic [1:0]       tx_valid;
  logic [PTR_W-1:0] tx_wr_ptr, tx_rd_ptr, rx_wr_ptr, rx_rd_ptr;
  int               n_chk, n_fail;

  epbuf_ctrl #(.PTR_W(PTR_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .tx_wr_inc(tx_wr_inc), .tx_rd_inc(tx_rd_inc), .rx_wr_inc(rx_wr_inc),
    .rx_rd_inc(rx_rd_inc), .pkt_sent(pkt_sent), .tx_full(tx_full),
    .tx_valid(tx_valid), .tx_fill_sel(tx_fill_sel), .tx_send_sel(tx_send_sel),
    .tx_wr_ptr(tx_wr_ptr), .tx_rd_ptr(tx_rd_ptr), .rx_wr_ptr(rx_wr_ptr),
    .rx_rd_ptr(rx_rd_ptr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // row: {cv, code, twi, tri, rwi, rri, sent} {valid, fill, send, full, twp, trp, rwp, rrp} req
  localparam logic [ROW_W-1:0] TBL [N_ROW] = '{
    {1'b0,8'h00,5'b10000, 2'b00,3'b000,6'd1,6'd0,6'd0,6'd0, 4'd3},  // R3 write into free buffer
    {1'b0,8'h00,5'b10000, 2'b00,3'b000,6'd2,6'd0,6'd0,6'd0, 4'd3},
    {1'b1,8'h0E,5'b00000, 2'b01,3'b100,6'd0,6'd0,6'd0,6'd0, 4'd2},  // R2 validate buffer 0
    {1'b0,8'h00,5'b10000, 2'b01,3'b100,6'd1,6'd0,6'd0,6'd0, 4'd3},
    {1'b0,8'h00,5'b01000, 2'b01,3'b100,6'd1,6'd1,6'd0,6'd0, 4'd10}, // R10 read from valid send buffer
    {1'b1,8'h0E,5'b00000, 2'b11,3'b001,6'd0,6'd1,6'd0,6'd0, 4'd9},  // R9 both valid -> full
    {1'b0,8'h00,5'b10000, 2'b11,3'b001,6'd0,6'd1,6'd0,6'd0, 4'd3},  // R3 write blocked
    {1'b1,8'h0E,5'b00000, 2'b11,3'b001,6'd0,6'd1,6'd0,6'd0, 4'd2},  // R2 validate while full
    {1'b1,8'h0A,5'b00100, 2'b11,3'b001,6'd0,6'd1,6'd1,6'd0, 4'd1},  // R1 unknown code, R12
    {1'b1,8'h0F,5'b00000, 2'b10,3'b010,6'd0,6'd0,6'd1,6'd0, 4'd4},  // R4 R6 clear oldest
    {1'b0,8'h00,5'b10000, 2'b10,3'b010,6'd1,6'd0,6'd1,6'd0, 4'd3},
    {1'b1,8'h10,5'b10000, 2'b10,3'b010,6'd0,6'd0,6'd0,6'd0, 4'd8},  // R8 restart beats write
    {1'b0,8'h00,5'b00001, 2'b00,3'b000,6'd0,6'd0,6'd0,6'd0, 4'd7},  // R7 auto release
    {1'b1,8'h0F,5'b00000, 2'b00,3'b000,6'd0,6'd0,6'd0,6'd0, 4'd5},  // R5 clear on empty
    {1'b1,8'h0E,5'b00000, 2'b01,3'b100,6'd0,6'd0,6'd0,6'd0, 4'd2},
    {1'b1,8'h0E,5'b00000, 2'b11,3'b001,6'd0,6'd0,6'd0,6'd0, 4'd9},
    {1'b1,8'h0F,5'b00001, 2'b00,3'b000,6'd0,6'd0,6'd0,6'd0, 4'd7},  // R7 clear + sent free both
    {1'b0,8'h00,5'b01000, 2'b00,3'b000,6'd0,6'd0,6'd0,6'd0, 4'd10}, // R10 read with none valid
    {1'b0,8'h00,5'b00110, 2'b00,3'b000,6'd0,6'd0,6'd1,6'd1, 4'd12}  // R12 both rx pointers
  };

  function automatic logic [EX_W-1:0] outs();
    return {tx_valid, tx_fill_sel, tx_send_sel, tx_full, tx_wr_ptr, tx_rd_ptr, rx_wr_ptr, rx_rd_ptr};
  endfunction

  task automatic check(input string req, input logic [EX_W-1:0] act, input logic [EX_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    {cmd_valid, cmd_code, tx_wr_inc, tx_rd_inc, rx_wr_inc, rx_rd_inc, pkt_sent} = '0;
  endtask

  task automatic drive(input logic [IN_W-1:0] s);
    @(negedge clk);
    {cmd_valid, cmd_code, tx_wr_inc, tx_rd_inc, rx_wr_inc, rx_rd_inc, pkt_sent} = s;
    @(posedge clk);
    #1 idle();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    idle();
    rst_n = 1'b0;
    #1 check("R11", outs(), '0);  // asynchronous: zero before any edge
    do_reset();
    #1 check("R11", outs(), '0);

    for (int i = 0; i < N_ROW; i++) begin
      drive(TBL[i][ROW_W-1 -: IN_W]);
      check($sformatf("R%0d", TBL[i][3:0]), outs(), TBL[i][EX_W+3:4]);
    end

    // R3: write pointer wraps modulo 2^PTR_W
    for (int i = 0; i < 63; i++) drive({1'b0, 8'h00, 5'b10000});
    check("R3", outs(), {2'b00, 3'b000, 6'd63, 6'd0, 6'd1, 6'd1});
    drive({1'b0, 8'h00, 5'b10000});
    check("R3", outs(), {2'b00, 3'b000, 6'd0, 6'd0, 6'd1, 6'd1});

    // R4: two clears needed to free both buffers
    drive({1'b1, 8'h0E, 5'b00000});
    drive({1'b1, 8'h0E, 5'b00000});
    drive({1'b1, 8'h0F, 5'b00000});
    check("R4", outs(), {2'b10, 3'b010, 6'd0, 6'd0, 6'd1, 6'd1});
    drive({1'b1, 8'h0F, 5'b00000});
    check("R4", outs(), {2'b00, 3'b000, 6'd0, 6'd0, 6'd1, 6'd1});

    // R11: reset taken mid-run with state set
    drive({1'b1, 8'h0E, 5'b00000});
    @(negedge clk) rst_n = 1'b0;
    #1 check("R11", outs(), '0);
    @(negedge clk) rst_n = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule